// File: doc/BRIEF.md
# Predicated Move and Load Unit

This execution-stage unit runs instructions whose effect is gated by a condition register operand. A control dependence becomes a data dependence: the instruction always enters the pipeline and always uses its slot. Whether it takes effect is settled at the register-write end. There are two predicated forms. The zero-gated move copies its source to the destination only when the condition operand is zero. The nonzero-gated load reads memory only when the condition operand is nonzero. Unconditional move and load opcodes use the same datapath with the predicate forced true.

An instruction is accepted on a clock edge where `valid_i` and `ready_o` are both high. It is resolved in the next cycle. A move writes in that cycle. A load either raises a memory request or, if its effective address is misaligned or out of range, raises the exception flag. A requested load then waits for the memory response and writes the register file in the cycle the response arrives. An annulled instruction (false predicate) spends its resolve cycle doing nothing: no write, no request and no exception, whatever its address.

Top module: `pred_exec_unit`

## Requirements
- R1: After reset, `wr_en_o`, `mem_req_o` and `exc_o` are low and `ready_o` is high.
- R2: Opcode 2 (zero-gated move) accepted with `cond_i` equal to 0 drives `wr_en_o` high in the next cycle, with `wr_addr_o` = `rd_i` and `wr_data_o` = `src_i`.
- R3: Opcode 4 (nonzero-gated load) accepted with `cond_i` nonzero and a good address drives `mem_req_o` in the next cycle, with `mem_addr_o` = `src_i` + sign-extended `disp_i`.
- R4: An instruction whose predicate is false still uses its resolve cycle, but in that cycle drives no write, no request and no exception, and `ready_o` stays high.
- R5: A load with a true predicate whose address has either of its low 2 bits set, or is at or above `ADDR_LIMIT` (default 0x10000), raises `exc_o` for one cycle and makes no request and no write. With a false predicate, the same address raises nothing.
- R6: While a load is outstanding, the cycle in which `mem_rvalid_i` is high drives `wr_en_o` with `wr_data_o` = `mem_rdata_i` and `wr_addr_o` set to the load's destination.
- R7: `ready_o` is low from the request cycle through the response cycle. Instructions offered in that window are not taken.
- R8: Opcode 1 (move) and opcode 3 (load) act with their predicate true, whatever the value of `cond_i`.
- R9: Opcodes 0, 5, 6 and 7 have no effect: no write, no request and no exception.
- R10: `mem_rvalid_i` with no load outstanding causes no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction offered |
| ready_o | output | 1 | Unit can accept an instruction |
| op_i | input | 3 | Opcode |
| rd_i | input | 5 | Destination register index |
| src_i | input | 32 | Move source / load base |
| cond_i | input | 32 | Predicate operand |
| disp_i | input | 16 | Signed load displacement |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Read address |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 32 | Read response data |
| wr_en_o | output | 1 | Register write enable |
| wr_addr_o | output | 5 | Register write index |
| wr_data_o | output | 32 | Register write data |
| exc_o | output | 1 | Address exception |

## Verification
The hardest case to reach from the ports is an annulled load whose address would fault. It must stay silent, while an identical load with a true predicate raises `exc_o`. The stimulus issues both back to back with the same misaligned, out-of-range address and changes only `cond_i`. A second hard case is an instruction offered while a load is outstanding. The bench holds `valid_i` high in the waiting window and then confirms that no extra write appears after the response.

// File: rtl/pred_exec_pkg.sv
package pred_exec_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_MOV   = 3'd1,
    OP_CMOVZ = 3'd2,
    OP_LD    = 3'd3,
    OP_LDNZ  = 3'd4
  } op_e;
endpackage

// File: rtl/pred_exec_decode.sv
module pred_exec_decode import pred_exec_pkg::*; #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned DISP_W     = 16,
  parameter int unsigned ALIGN_W    = 2,
  parameter logic [XLEN-1:0] ADDR_LIMIT = 32'h0001_0000
) (
  input  logic [2:0]        op_i,
  input  logic [XLEN-1:0]   src_i,
  input  logic [XLEN-1:0]   cond_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic              is_move_o,
  output logic              is_load_o,
  output logic              pred_o,
  output logic              fault_o,
  output logic [XLEN-1:0]   addr_o
);
  localparam int unsigned EXT_W = XLEN - DISP_W;

  logic misal;
  logic cond_zero;

  assign cond_zero = (cond_i == '0);
  assign addr_o    = src_i + {{EXT_W{disp_i[DISP_W-1]}}, disp_i};

  generate
    if (ALIGN_W == 0) begin : g_byte
      assign misal = 1'b0;
    end else begin : g_word
      assign misal = |addr_o[ALIGN_W-1:0];
    end
  endgenerate

  assign fault_o = misal || (addr_o >= ADDR_LIMIT);

  always_comb begin
    is_move_o = 1'b0;
    is_load_o = 1'b0;
    pred_o    = 1'b0;
    unique case (op_i)
      OP_MOV:   begin is_move_o = 1'b1; pred_o = 1'b1;       end
      OP_CMOVZ: begin is_move_o = 1'b1; pred_o = cond_zero;  end
      OP_LD:    begin is_load_o = 1'b1; pred_o = 1'b1;       end
      OP_LDNZ:  begin is_load_o = 1'b1; pred_o = !cond_zero; end
      default:  ;
    endcase
  end
endmodule

// File: rtl/pred_exec_stage.sv
module pred_exec_stage #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned RA_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_i,
  input  logic            is_move_i,
  input  logic            is_load_i,
  input  logic            pred_i,
  input  logic            fault_i,
  input  logic [RA_W-1:0] rd_i,
  input  logic [XLEN-1:0] data_i,
  input  logic [XLEN-1:0] addr_i,
  output logic            vld_o,
  output logic            is_move_o,
  output logic            is_load_o,
  output logic            pred_o,
  output logic            fault_o,
  output logic [RA_W-1:0] rd_o,
  output logic [XLEN-1:0] data_o,
  output logic [XLEN-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o     <= 1'b0;
      is_move_o <= 1'b0;
      is_load_o <= 1'b0;
      pred_o    <= 1'b0;
      fault_o   <= 1'b0;
      rd_o      <= '0;
      data_o    <= '0;
      addr_o    <= '0;
    end else begin
      vld_o <= take_i;
      if (take_i) begin
        is_move_o <= is_move_i;
        is_load_o <= is_load_i;
        pred_o    <= pred_i;
        fault_o   <= fault_i;
        rd_o      <= rd_i;
        data_o    <= data_i;
        addr_o    <= addr_i;
      end
    end
  end
endmodule

// File: rtl/pred_exec_resolve.sv
module pred_exec_resolve #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned RA_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            vld_i,
  input  logic            is_move_i,
  input  logic            is_load_i,
  input  logic            pred_i,
  input  logic            fault_i,
  input  logic [RA_W-1:0] rd_i,
  input  logic [XLEN-1:0] data_i,
  input  logic            rvalid_i,
  input  logic [XLEN-1:0] rdata_i,
  output logic            req_o,
  output logic            exc_o,
  output logic            wr_en_o,
  output logic [RA_W-1:0] wr_addr_o,
  output logic [XLEN-1:0] wr_data_o,
  output logic            ready_o
);
  logic            live;
  logic            wait_q;
  logic [RA_W-1:0] ld_rd_q;

  // predicate applied here, at the write end
  assign live    = vld_i && pred_i;
  assign req_o   = live && is_load_i && !fault_i;
  assign exc_o   = live && is_load_i && fault_i;
  assign ready_o = !wait_q && !req_o;

  assign wr_en_o   = wait_q ? rvalid_i : (live && is_move_i);
  assign wr_addr_o = wait_q ? ld_rd_q : rd_i;
  assign wr_data_o = wait_q ? rdata_i : data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q  <= 1'b0;
      ld_rd_q <= '0;
    end else if (req_o) begin
      wait_q  <= 1'b1;
      ld_rd_q <= rd_i;
    end else if (wait_q && rvalid_i) begin
      wait_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/pred_exec_unit.sv
module pred_exec_unit import pred_exec_pkg::*; #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned DISP_W     = 16,
  parameter int unsigned RA_W       = 5,
  parameter int unsigned ALIGN_W    = 2,
  parameter logic [XLEN-1:0] ADDR_LIMIT = 32'h0001_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic [2:0]        op_i,
  input  logic [RA_W-1:0]   rd_i,
  input  logic [XLEN-1:0]   src_i,
  input  logic [XLEN-1:0]   cond_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic              mem_req_o,
  output logic [XLEN-1:0]   mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [XLEN-1:0]   mem_rdata_i,
  output logic              wr_en_o,
  output logic [RA_W-1:0]   wr_addr_o,
  output logic [XLEN-1:0]   wr_data_o,
  output logic              exc_o
);
  logic            d_move, d_load, d_pred, d_fault;
  logic [XLEN-1:0] d_addr;
  logic            s_vld, s_move, s_load, s_pred, s_fault;
  logic [RA_W-1:0] s_rd;
  logic [XLEN-1:0] s_data, s_addr;
  logic            take;

  assign take       = valid_i && ready_o;
  assign mem_addr_o = s_addr;

  pred_exec_decode #(
    .XLEN(XLEN), .DISP_W(DISP_W), .ALIGN_W(ALIGN_W), .ADDR_LIMIT(ADDR_LIMIT)
  ) u_dec (
    .op_i(op_i), .src_i(src_i), .cond_i(cond_i), .disp_i(disp_i),
    .is_move_o(d_move), .is_load_o(d_load), .pred_o(d_pred),
    .fault_o(d_fault), .addr_o(d_addr)
  );

  pred_exec_stage #(.XLEN(XLEN), .RA_W(RA_W)) u_stg (
    .clk_i(clk_i), .rst_ni(rst_ni), .take_i(take),
    .is_move_i(d_move), .is_load_i(d_load), .pred_i(d_pred), .fault_i(d_fault),
    .rd_i(rd_i), .data_i(src_i), .addr_i(d_addr),
    .vld_o(s_vld), .is_move_o(s_move), .is_load_o(s_load), .pred_o(s_pred),
    .fault_o(s_fault), .rd_o(s_rd), .data_o(s_data), .addr_o(s_addr)
  );

  pred_exec_resolve #(.XLEN(XLEN), .RA_W(RA_W)) u_res (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(s_vld),
    .is_move_i(s_move), .is_load_i(s_load), .pred_i(s_pred), .fault_i(s_fault),
    .rd_i(s_rd), .data_i(s_data),
    .rvalid_i(mem_rvalid_i), .rdata_i(mem_rdata_i),
    .req_o(mem_req_o), .exc_o(exc_o), .wr_en_o(wr_en_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .ready_o(ready_o)
  );
endmodule

// File: rtl/pred_exec_unit_chk.sv
module pred_exec_unit_chk #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned ALIGN_W    = 2,
  parameter logic [XLEN-1:0] ADDR_LIMIT = 32'h0001_0000
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic            ready_o,
  input logic            mem_req_o,
  input logic [XLEN-1:0] mem_addr_o,
  input logic            wr_en_o,
  input logic            exc_o
);
  p_req_exc_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && exc_o));

  p_req_good_addr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o < ADDR_LIMIT) &&
                  ((mem_addr_o & ((XLEN'(1) << ALIGN_W) - XLEN'(1))) == '0));

  p_req_after_take_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> $past(valid_i && ready_o));

  p_exc_after_take_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> $past(valid_i && ready_o));

  p_req_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !ready_o && !wr_en_o);

  p_exc_no_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> !wr_en_o && ready_o);
endmodule

bind pred_exec_unit pred_exec_unit_chk #(
  .XLEN(XLEN), .ALIGN_W(ALIGN_W), .ADDR_LIMIT(ADDR_LIMIT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .ready_o(ready_o),
  .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .wr_en_o(wr_en_o), .exc_o(exc_o)
);

// File: tb/sim_pred_exec_unit.sv
`timescale 1ns/1ps
module sim_pred_exec_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        ready;
  logic [2:0]  op = '0;
  logic [4:0]  rd = '0;
  logic [31:0] src = '0, cond = '0;
  logic [15:0] disp = '0;
  logic        req;
  logic [31:0] addr;
  logic        rvalid = 1'b0;
  logic [31:0] rdata = '0;
  logic        wr_en;
  logic [4:0]  wr_addr;
  logic [31:0] wr_data;
  logic        exc;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pred_exec_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .ready_o(ready),
    .op_i(op), .rd_i(rd), .src_i(src), .cond_i(cond), .disp_i(disp),
    .mem_req_o(req), .mem_addr_o(addr), .mem_rvalid_i(rvalid), .mem_rdata_i(rdata),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .exc_o(exc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge; returns at the following negedge (resolve cycle)
  task automatic issue(input logic [2:0] o, input logic [4:0] r, input logic [31:0] s,
                       input logic [31:0] c, input logic [15:0] d);
    @(negedge clk);
    valid = 1'b1; op = o; rd = r; src = s; cond = c; disp = d;
    @(negedge clk);
    valid = 1'b0;
    #0.5;
  endtask

  task automatic expect_quiet(input string tag);
    chk({tag, " wr_en"}, 32'(wr_en), 0);
    chk({tag, " req"},   32'(req),   0);
    chk({tag, " exc"},   32'(exc),   0);
    chk({tag, " ready"}, 32'(ready), 1);
  endtask

  task automatic t_reset;
    expect_quiet("R1 reset");
  endtask

  task automatic t_cmovz;
    issue(3'd2, 5'd7, 32'hCAFE_0001, 32'd0, 16'd0);
    chk("R2 cmovz wr_en", 32'(wr_en), 1);
    chk("R2 cmovz rd", 32'(wr_addr), 7);
    chk("R2 cmovz data", wr_data, 32'hCAFE_0001);
    issue(3'd2, 5'd8, 32'h1234_5678, 32'd5, 16'd0);
    expect_quiet("R4 cmovz annulled");
  endtask

  task automatic t_ldnz;
    issue(3'd4, 5'd3, 32'h0000_0100, 32'd1, 16'hFFF8);
    chk("R3 ldnz req", 32'(req), 1);
    chk("R3 ldnz addr", addr, 32'h0000_00F8);
    chk("R7 ready in req", 32'(ready), 0);
    @(negedge clk); #0.5;
    chk("R7 ready waiting", 32'(ready), 0);
    chk("R6 no early write", 32'(wr_en), 0);
    valid = 1'b1; op = 3'd2; rd = 5'd9; src = 32'hDEAD; cond = 0;  // offered while busy
    @(negedge clk);
    rvalid = 1'b1; rdata = 32'hA5A5_0F0F;
    #0.5;
    chk("R6 load wr_en", 32'(wr_en), 1);
    chk("R6 load rd", 32'(wr_addr), 3);
    chk("R6 load data", wr_data, 32'hA5A5_0F0F);
    @(negedge clk);
    rvalid = 1'b0; valid = 1'b0;
    #0.5;
    chk("R7 ready after rsp", 32'(ready), 1);
    chk("R7 busy offer dropped", 32'(wr_en), 0);
    @(negedge clk); #0.5;
    chk("R7 busy offer dropped later", 32'(wr_en), 0);
  endtask

  task automatic t_annul_fault;
    issue(3'd4, 5'd4, 32'h0002_0001, 32'd0, 16'd0);
    expect_quiet("R4 R5 annulled fault");
    issue(3'd4, 5'd4, 32'h0002_0001, 32'd9, 16'd0);
    chk("R5 misal+range exc", 32'(exc), 1);
    chk("R5 no req", 32'(req), 0);
    chk("R5 no write", 32'(wr_en), 0);
    issue(3'd4, 5'd4, 32'h0000_0102, 32'd9, 16'd0);
    chk("R5 misaligned exc", 32'(exc), 1);
    issue(3'd4, 5'd4, 32'h0000_FFFC, 32'd9, 16'd4);
    chk("R5 at limit exc", 32'(exc), 1);
    @(negedge clk); #0.5;
    chk("R5 exc one cycle", 32'(exc), 0);
  endtask

  task automatic t_uncond;
    issue(3'd1, 5'd11, 32'h0BAD_F00D, 32'hFFFF_FFFF, 16'd0);
    chk("R8 mov wr_en", 32'(wr_en), 1);
    chk("R8 mov data", wr_data, 32'h0BAD_F00D);
    issue(3'd3, 5'd12, 32'h0000_0200, 32'd0, 16'h0010);
    chk("R8 ld req", 32'(req), 1);
    chk("R8 ld addr", addr, 32'h0000_0210);
    @(negedge clk);
    rvalid = 1'b1; rdata = 32'h0000_0042;
    #0.5;
    chk("R8 ld write", wr_data, 32'h0000_0042);
    @(negedge clk);
    rvalid = 1'b0;
  endtask

  task automatic t_reserved;
    for (int o = 5; o < 9; o++) begin
      issue(o == 8 ? 3'd0 : 3'(o), 5'd1, 32'h10, 32'd1, 16'd0);
      expect_quiet("R9 reserved op");
    end
  endtask

  task automatic t_stray_rsp;
    @(negedge clk);
    rvalid = 1'b1; rdata = 32'hFFFF_0000;
    #0.5;
    chk("R10 stray rsp", 32'(wr_en), 0);
    @(negedge clk);
    rvalid = 1'b0;
    #0.5;
    chk("R10 ready", 32'(ready), 1);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #0.5;
    t_reset();
    rst_n = 1'b1;
    @(negedge clk); #0.5;
    t_reset();
    t_cmovz();
    t_ldnz();
    t_annul_fault();
    t_uncond();
    t_reserved();
    t_stray_rsp();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule